// File: doc/BRIEF.md
# CSR Access Checker with Read-Modify-Write

This block carries out one control-register instruction per cycle for a processor pipeline. It handles three kinds of operation: a swap (read, then write the source), a bit-set and a bit-clear. Before anything happens it decides whether the access is legal. The decision uses two things: attributes encoded directly in the 12-bit register address, and the hart's current privilege level.

The register file itself sits behind a plain port. The port takes an address, returns read data in the same cycle, and accepts a write strobe with write data. The block does not know what any individual register holds. It only computes the old value to return to the destination register, the new value to store, and a fault flag that the pipeline turns into an illegal-instruction trap.

A read-only group of user counter registers can be hidden from lower privilege levels. Two enable masks are supplied, one for user mode and one for supervisor mode. Each mask has one bit per counter.

Top module: `csr_rmw_unit`

## Requirements
- R1: The privilege needed for an address is the value of address bits [9:8]. Privilege levels are encoded user=0, supervisor=1, reserved=2, machine=3. A request whose current privilege is numerically below the needed level sets `access_fault`.
- R2: An address whose bits [11:10] are 2'b11 is read-only. A request that counts as a write to such an address sets `access_fault`.
- R3: Operation codes are 01 swap, 10 set and 11 clear. A legal swap always writes: it asserts `port_we` with `port_wdata` equal to `req_src`.
- R4: A legal set whose `req_src_nz` is high writes `req_src | port_rdata`. A legal clear whose `req_src_nz` is high writes `~req_src & port_rdata`.
- R5: A set or clear with `req_src_nz` low is a pure read. It never asserts `port_we`, and it is not subject to the read-only check of R2.
- R6: On every legal request, `rd_old` equals `port_rdata` of the same cycle. That is the value from before any write.
- R7: Addresses 0xC00 to 0xC1F are user counters. In user mode, access to one of them needs bit (address mod 32) of `user_ctr_en`. In supervisor mode it needs the same bit of `super_ctr_en`. In machine and reserved mode no bit is needed. A clear bit sets `access_fault`.
- R8: While `access_fault` is high, `port_we` is low and `rd_old` is zero.
- R9: With `req_valid` low, `port_we`, `access_fault` and `rd_old` are all low.
- R10: Operation code 00 is reserved. A valid request carrying it sets `access_fault`.
- R11: The whole operation is combinational within one cycle. `port_addr` always equals `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Operation code (01 swap, 10 set, 11 clear, 00 reserved) |
| req_addr | input | 12 | Register address |
| req_src | input | XLEN | Source operand |
| req_src_nz | input | 1 | Source register index is nonzero |
| cur_priv | input | 2 | Current privilege level |
| user_ctr_en | input | CNT_W | Counter enables applied in user mode |
| super_ctr_en | input | CNT_W | Counter enables applied in supervisor mode |
| port_rdata | input | XLEN | Read data from the register port |
| port_addr | output | 12 | Address to the register port |
| port_we | output | 1 | Write strobe to the register port |
| port_wdata | output | XLEN | Value to store |
| rd_old | output | XLEN | Old register value for write-back |
| access_fault | output | 1 | Illegal-instruction indication |

## Verification
The block holds no state, so a wrong internal decision shows up at the ports in the same cycle as the request. A misdecoded attribute shows as a wrong `access_fault`. A wrongly gated write shows as a stray or missing `port_we`. A wrong merge shows as a bad `port_wdata` bit. The sweeps therefore cover every pairing of privilege, the four upper address bits, operation and source-index flag, plus every counter index at every privilege level. Each combination is checked right after its inputs settle.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } priv_lvl_e;

    localparam int          ADDR_W   = 12;
    localparam logic [11:0] CTR_BASE = 12'hC00;
endpackage

// File: rtl/csr_access_guard.sv
module csr_access_guard
    import csr_rmw_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        op,
    input  logic              src_nz,
    input  logic [1:0]        priv,
    input  logic [CNT_W-1:0]  user_en,
    input  logic [CNT_W-1:0]  super_en,
    output logic              wants_write,
    output logic              illegal
);
    localparam int IDX_W = $clog2(CNT_W);

    logic             bad_op;
    logic [1:0]       need_lvl;
    logic             read_only;
    logic             is_ctr;
    logic [CNT_W-1:0] ctr_mask;
    logic             ctr_ok;

    // Classify the operation: which codes write, which code is reserved.
    always_comb begin
        wants_write = 1'b0;
        bad_op      = 1'b0;
        unique case (csr_op_e'(op))
            OP_SWAP:        wants_write = 1'b1;
            OP_SET, OP_CLR: wants_write = src_nz;
            OP_NONE:        bad_op      = 1'b1;
        endcase
    end

    // Pick the counter enable mask that applies at this privilege level.
    always_comb begin
        unique case (priv_lvl_e'(priv))
            LVL_USER:           ctr_mask = user_en;
            LVL_SUPER:          ctr_mask = super_en;
            LVL_RSVD, LVL_MACH: ctr_mask = '1;
        endcase
    end

    assign need_lvl  = addr[9:8];
    assign read_only = (addr[11:10] == 2'b11);
    assign is_ctr    = (addr[ADDR_W-1:IDX_W] == CTR_BASE[ADDR_W-1:IDX_W]);
    assign ctr_ok    = ctr_mask[addr[IDX_W-1:0]];

    assign illegal = bad_op
                   | (priv < need_lvl)
                   | (wants_write & read_only)
                   | (is_ctr & ~ctr_ok);
endmodule

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] old,
    output logic [XLEN-1:0] result
);
    always_comb begin
        unique case (csr_op_e'(op))
            OP_SWAP: result = src;
            OP_SET:  result = src | old;
            OP_CLR:  result = ~src & old;
            OP_NONE: result = old;
        endcase
    end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_W = 32
) (
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [11:0]       req_addr,
    input  logic [XLEN-1:0]   req_src,
    input  logic              req_src_nz,
    input  logic [1:0]        cur_priv,
    input  logic [CNT_W-1:0]  user_ctr_en,
    input  logic [CNT_W-1:0]  super_ctr_en,
    input  logic [XLEN-1:0]   port_rdata,
    output logic [11:0]       port_addr,
    output logic              port_we,
    output logic [XLEN-1:0]   port_wdata,
    output logic [XLEN-1:0]   rd_old,
    output logic              access_fault
);
    logic wants_write;
    logic illegal;

    csr_access_guard #(.CNT_W(CNT_W)) u_guard (
        .addr        (req_addr),
        .op          (req_op),
        .src_nz      (req_src_nz),
        .priv        (cur_priv),
        .user_en     (user_ctr_en),
        .super_en    (super_ctr_en),
        .wants_write (wants_write),
        .illegal     (illegal)
    );

    csr_rmw_alu #(.XLEN(XLEN)) u_alu (
        .op     (req_op),
        .src    (req_src),
        .old    (port_rdata),
        .result (port_wdata)
    );

    assign port_addr    = req_addr;
    assign access_fault = req_valid & illegal;
    assign port_we      = req_valid & ~illegal & wants_write;
    assign rd_old       = (req_valid & ~illegal) ? port_rdata : '0;
endmodule

// File: rtl/csr_rmw_checker.sv
module csr_rmw_checker #(
    parameter int XLEN = 32
) (
    input logic            req_valid,
    input logic [1:0]      req_op,
    input logic [11:0]     req_addr,
    input logic [XLEN-1:0] req_src,
    input logic            req_src_nz,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] port_rdata,
    input logic            port_we,
    input logic [XLEN-1:0] port_wdata,
    input logic [XLEN-1:0] rd_old,
    input logic            access_fault
);
    always_comb begin
        if (!$isunknown({req_valid, req_op, req_addr, req_src, req_src_nz,
                         cur_priv, port_rdata, port_we, access_fault})) begin
            a_r8_no_write_on_fault: assert (!(port_we && access_fault));
            a_r9_idle_quiet: assert (req_valid || (!port_we && !access_fault && rd_old == '0));
            a_r1_level_respected: assert (!port_we || cur_priv >= req_addr[9:8]);
            a_r2_read_only_kept: assert (!port_we || req_addr[11:10] != 2'b11);
            a_r5_x0_no_write: assert (!(port_we && req_op != 2'b01 && !req_src_nz));
            a_r3_swap_data: assert (!(port_we && req_op == 2'b01) || port_wdata == req_src);
            a_r4_set_data: assert (!(port_we && req_op == 2'b10) || port_wdata == (req_src | port_rdata));
        end
    end
endmodule

bind csr_rmw_unit csr_rmw_checker #(.XLEN(XLEN)) u_chk (
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .req_src      (req_src),
    .req_src_nz   (req_src_nz),
    .cur_priv     (cur_priv),
    .port_rdata   (port_rdata),
    .port_we      (port_we),
    .port_wdata   (port_wdata),
    .rd_old       (rd_old),
    .access_fault (access_fault)
);

// File: tb/tb_csr_rmw_unit.sv
module tb_csr_rmw_unit;
    localparam int XLEN  = 32;
    localparam int CNT_W = 32;

    logic              clk = 1'b0;
    logic              req_valid;
    logic [1:0]        req_op;
    logic [11:0]       req_addr;
    logic [XLEN-1:0]   req_src;
    logic              req_src_nz;
    logic [1:0]        cur_priv;
    logic [CNT_W-1:0]  user_ctr_en;
    logic [CNT_W-1:0]  super_ctr_en;
    logic [XLEN-1:0]   port_rdata;
    logic [11:0]       port_addr;
    logic              port_we;
    logic [XLEN-1:0]   port_wdata;
    logic [XLEN-1:0]   rd_old;
    logic              access_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    csr_rmw_unit #(.XLEN(XLEN), .CNT_W(CNT_W)) dut (
        .req_valid, .req_op, .req_addr, .req_src, .req_src_nz, .cur_priv,
        .user_ctr_en, .super_ctr_en, .port_rdata, .port_addr, .port_we,
        .port_wdata, .rd_old, .access_fault
    );

    task automatic check(input string tag, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (op=%0d addr=%h priv=%0d nz=%0b)",
                     tag, act, exp, req_op, req_addr, cur_priv, req_src_nz);
        end
    endtask

    // Compare all outputs against values derived from the requirements.
    task automatic verify();
        logic wr, ctr, en_bit, ill, we;
        logic [31:0] mask;
        logic [XLEN-1:0] exp_w;
        wr  = (req_op == 2'b01) || (req_op[1] && req_src_nz);
        ctr = (req_addr >= 12'hC00) && (req_addr <= 12'hC1F);
        mask = (cur_priv == 2'd0) ? user_ctr_en : (cur_priv == 2'd1) ? super_ctr_en : '1;
        en_bit = mask[req_addr[4:0]];
        ill = req_valid && ((req_op == 2'b00) || (cur_priv < req_addr[9:8]) ||
                            (wr && req_addr[11:10] == 2'b11) || (ctr && !en_bit));
        we  = req_valid && !ill && wr;
        exp_w = (req_op == 2'b01) ? req_src :
                (req_op == 2'b10) ? (req_src | port_rdata) : (~req_src & port_rdata);
        #1;
        check("R1 R2 R7 R10 fault", {31'd0, access_fault}, {31'd0, ill});
        check("R3 R4 R5 R8 R9 strobe", {31'd0, port_we}, {31'd0, we});
        if (we) check("R3 R4 wdata", port_wdata, exp_w);
        check("R6 R8 R9 old value", rd_old, (req_valid && !ill) ? port_rdata : '0);
        check("R11 port address", {20'd0, port_addr}, {20'd0, req_addr});
    endtask

    initial begin
        req_valid = 0; req_op = 0; req_addr = 0; req_src = 0; req_src_nz = 0;
        cur_priv = 0; user_ctr_en = 32'hA5C3_0F1E; super_ctr_en = 32'h5A3C_F0E1;
        port_rdata = 32'h1234_5678;
        @(negedge clk);
        verify();  // R9 quiet with no request

        // Full sweep of privilege, upper address nibble, operation, source flag.
        for (int v = 0; v < 2; v++)
            for (int p = 0; p < 4; p++)
                for (int h = 0; h < 16; h++)
                    for (int o = 0; o < 4; o++)
                        for (int n = 0; n < 2; n++) begin
                            @(negedge clk);
                            req_valid  = v[0];
                            cur_priv   = p[1:0];
                            req_addr   = {h[3:0], 8'h47};
                            req_op     = o[1:0];
                            req_src_nz = n[0];
                            req_src    = 32'hF0F0_3C3C ^ (h * 32'h0101_0101);
                            port_rdata = 32'h0FF0_A55A + p * 32'h1111_0000 + o;
                            verify();
                        end

        // Counter gating: every index at every level, read and swap attempts.
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < 32; i++)
                for (int k = 0; k < 2; k++) begin
                    @(negedge clk);
                    req_valid  = 1'b1;
                    cur_priv   = p[1:0];
                    req_addr   = 12'hC00 + i[11:0];
                    req_op     = k[0] ? 2'b01 : 2'b10;
                    req_src_nz = 1'b0;
                    req_src    = 32'hDEAD_BEEF;
                    port_rdata = 32'h0000_1000 + i;
                    verify();  // R7, and R2 for the swap attempt
                end

        // Boundary just past the counter page: not gated (R7).
        @(negedge clk);
        cur_priv = 2'd0; req_addr = 12'hC20; req_op = 2'b10; req_src_nz = 1'b0;
        user_ctr_en = '0;
        verify();
        // Clear with all-ones source empties the register (R4).
        @(negedge clk);
        cur_priv = 2'd3; req_addr = 12'h340; req_op = 2'b11; req_src_nz = 1'b1;
        req_src = '1; port_rdata = 32'hFFFF_FFFF;
        verify();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule